// File: doc/BRIEF.md
# Two-Source Conversion Request Arbiter

This block sits in front of an analog-to-digital converter back end and decides which of two request sources gets the converter next. Source 0 is a sequential queue and source 1 is a parallel scan. Each source presents a pending flag and the channel it wants converted. The arbiter evaluates the requests at the end of each arbitration round. It then issues a one-cycle start pulse together with the winning channel and the winning source number.

Each source has its own slot enable, a priority bit and a start-mode bit. A source whose start-mode bit is clear waits until the running conversion has finished. A source whose start-mode bit is set may abort a running conversion, but only when it has high priority and the running conversion belongs to a low-priority source. The aborted request stays pending and is granted again later. An arbitration-mode bit selects how rounds are timed. In permanent mode, rounds run back to back from reset. In on-demand mode, the round position is held at its first cycle while no enabled request is pending.

When the back end signals completion, the arbiter acknowledges the owning source so that the source can drop its request. Status outputs show whether a conversion is in progress, its channel, and whether it is still in its sample phase.

Top module: `conv_arbiter`

## Requirements
- R1: A source whose slot enable (`slot_en_i` bit 0 for source 0, bit 1 for source 1) is low is never granted.
- R2: Among eligible sources, a source whose priority bit is 1 beats one whose bit is 0, and source 0 wins when the two priority bits are equal. `src_o` is 0 for the queue source and 1 for the scan source.
- R3: A grant happens only in the last cycle of a round of ROUND_CYC cycles. `start_o` is high for exactly that one cycle, and `chan_o` and `src_o` are valid in the same cycle.
- R4: With `arb_on_demand_i`=1, the round position is held at its first cycle while no enabled request is pending, so a request raised from that state is started ROUND_CYC-1 cycles after it is raised. With `arb_on_demand_i`=0, rounds run continuously and any two starts are a multiple of ROUND_CYC cycles apart.
- R5: While a conversion runs, a source is not started if its start-mode bit (`inject_i`) is 0, if its priority bit is 0, or if the running conversion comes from a high-priority source.
- R6: A source that is eligible, has `inject_i`=1 and priority 1, and finds a running conversion from a priority-0 source is started at once. `cancel_o` is high with that start. The aborted source is not acknowledged, and it is granted again after the injected conversion ends.
- R7: A `conv_done_i` pulse during a conversion raises `ack_o` for the owning source only (bit 0 for source 0, bit 1 for source 1), in the same cycle. The owner is not eligible in that cycle, and another source may be started in that same cycle.
- R8: `busy_o` rises in the cycle after a start and falls in the cycle after a done that has no start beside it. While `busy_o` is high, `cur_chan_o` holds the started channel.
- R9: `sample_o` is high for SAMPLE_CYC cycles from the cycle after a start. A done cuts it short.
- R10: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_en_i | input | 2 | Per-source slot enable |
| prio_i | input | 2 | Per-source high-priority bit |
| inject_i | input | 2 | Per-source start mode: 1 = abort and inject, 0 = wait for finish |
| arb_on_demand_i | input | 1 | 1 = rounds held while nothing is pending, 0 = permanent rounds |
| q_pend_i | input | 1 | Queue source request pending |
| q_chan_i | input | CH_W | Queue source channel |
| s_pend_i | input | 1 | Scan source request pending |
| s_chan_i | input | CH_W | Scan source channel |
| conv_done_i | input | 1 | Back end conversion complete pulse |
| start_o | output | 1 | Conversion start pulse |
| chan_o | output | CH_W | Channel to convert, valid with start_o |
| src_o | output | 1 | Granted source, valid with start_o |
| cancel_o | output | 1 | The running conversion is aborted by this start |
| ack_o | output | 2 | Per-source completion acknowledge |
| busy_o | output | 1 | Conversion in progress |
| cur_chan_o | output | CH_W | Channel of the conversion in progress |
| sample_o | output | 1 | Running conversion is in its sample phase |

## Verification
The bench first runs with one slot disabled, which separates a correct slot mask from a plain priority pick. It then drives both sources at a high request rate under each priority setting, so that priority order and the tie rule decide every grant taken from idle. A directed abort scenario, in which a low-priority scan conversion is overtaken by a high-priority queue request, separates a correct cancel and retry from lost or duplicated acknowledges. Round timing is tried with a request raised from idle in on-demand mode and with gaps between starts measured in permanent mode. Long random stretches with all settings changing exercise done and grant in the same cycle, against a cycle-level model of every output.

// File: rtl/conv_arb_pkg.sv
package conv_arb_pkg;
  localparam int unsigned NSRC = 2;
  typedef enum logic {SRC_QUEUE = 1'b0, SRC_SCAN = 1'b1} src_e;
endpackage

// File: rtl/conv_arb_round.sv
module conv_arb_round #(
  parameter int unsigned ROUND_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic rnd_end_o
);
  localparam int unsigned CNT_W = (ROUND_CYC > 2) ? $clog2(ROUND_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUND_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign rnd_end_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (hold_i)    cnt_q <= '0;
    else if (rnd_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R4
  hold_no_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !rnd_end_o);
  // R3
  end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_end_o |=> !rnd_end_o);
endmodule

// File: rtl/conv_arb_pick.sv
module conv_arb_pick
  import conv_arb_pkg::*;
(
  input  logic [NSRC-1:0] slot_en_i,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] prio_i,
  input  logic [NSRC-1:0] inject_i,
  input  logic            owned_i,   // a conversion is registered as running
  input  logic            busy_i,    // running and not finishing this cycle
  input  logic            own_src_i,
  output logic            grant_o,
  output logic            gsrc_o
);
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    assign elig[s] = slot_en_i[s] & pend_i[s]
                   & ~(owned_i & (own_src_i == 1'(s)))
                   & (~busy_i | (inject_i[s] & prio_i[s] & ~prio_i[own_src_i]));
  end

  assign grant_o = |elig;
  assign gsrc_o  = elig[1] & (~elig[0] | (prio_i[1] & ~prio_i[0]));
endmodule

// File: rtl/conv_arb_track.sv
module conv_arb_track #(
  parameter int unsigned CH_W       = 3,
  parameter int unsigned SAMPLE_CYC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            src_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic            own_src_o,
  output logic [CH_W-1:0] own_chan_o,
  output logic            sample_o,
  output logic [1:0]      ack_o
);
  localparam int unsigned SMP_W = $clog2(SAMPLE_CYC + 1);

  logic [SMP_W-1:0] smp_q;
  logic             fin;

  assign fin        = done_i & busy_o;
  assign ack_o      = {fin & own_src_o, fin & ~own_src_o};
  assign sample_o   = (smp_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      own_src_o  <= 1'b0;
      own_chan_o <= '0;
      smp_q      <= '0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      own_src_o  <= src_i;
      own_chan_o <= chan_i;
      smp_q      <= SMP_W'(SAMPLE_CYC);
    end else if (fin) begin
      busy_o     <= 1'b0;
      smp_q      <= '0;
    end else if (smp_q != '0) begin
      smp_q      <= smp_q - 1'b1;
    end
  end

  // R7
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o) && ((ack_o != 2'b00) -> busy_o));
  // R8
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && own_chan_o == $past(chan_i));
  // R8
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !start_i) |=> !busy_o);
  // R9
  sample_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> sample_o);
endmodule

// File: rtl/conv_arbiter.sv
module conv_arbiter
  import conv_arb_pkg::*;
#(
  parameter int unsigned CH_W       = 3,
  parameter int unsigned ROUND_CYC  = 4,
  parameter int unsigned SAMPLE_CYC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] slot_en_i,
  input  logic [NSRC-1:0] prio_i,
  input  logic [NSRC-1:0] inject_i,
  input  logic            arb_on_demand_i,
  input  logic            q_pend_i,
  input  logic [CH_W-1:0] q_chan_i,
  input  logic            s_pend_i,
  input  logic [CH_W-1:0] s_chan_i,
  input  logic            conv_done_i,
  output logic            start_o,
  output logic [CH_W-1:0] chan_o,
  output logic            src_o,
  output logic            cancel_o,
  output logic [NSRC-1:0] ack_o,
  output logic            busy_o,
  output logic [CH_W-1:0] cur_chan_o,
  output logic            sample_o
);
  logic [NSRC-1:0] pend;
  logic            hold, rnd_end, grant, gsrc, busy_eff, own_src;

  assign pend     = {s_pend_i, q_pend_i};
  assign hold     = arb_on_demand_i & ~|(slot_en_i & pend);
  assign busy_eff = busy_o & ~conv_done_i;

  conv_arb_round #(.ROUND_CYC(ROUND_CYC)) u_round (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .rnd_end_o (rnd_end)
  );

  conv_arb_pick u_pick (
    .slot_en_i (slot_en_i),
    .pend_i    (pend),
    .prio_i    (prio_i),
    .inject_i  (inject_i),
    .owned_i   (busy_o),
    .busy_i    (busy_eff),
    .own_src_i (own_src),
    .grant_o   (grant),
    .gsrc_o    (gsrc)
  );

  assign start_o  = rnd_end & grant;
  assign src_o    = gsrc;
  assign chan_o   = (gsrc == SRC_SCAN) ? s_chan_i : q_chan_i;
  assign cancel_o = start_o & busy_eff;

  conv_arb_track #(.CH_W(CH_W), .SAMPLE_CYC(SAMPLE_CYC)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_o),
    .src_i      (gsrc),
    .chan_i     (chan_o),
    .done_i     (conv_done_i),
    .busy_o     (busy_o),
    .own_src_o  (own_src),
    .own_chan_o (cur_chan_o),
    .sample_o   (sample_o),
    .ack_o      (ack_o)
  );

  // R1
  slot_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> slot_en_i[src_o]);
  // R2
  tie_to_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !busy_o && (&slot_en_i) && q_pend_i && s_pend_i && prio_i[0] == prio_i[1])
      |-> src_o == SRC_QUEUE);
  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R6
  cancel_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> start_o && inject_i[src_o] && prio_i[src_o] && !prio_i[own_src]);
  // R5
  no_wait_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && busy_eff) |-> inject_i[src_o]);
endmodule

// File: tb/conv_arbiter_bench.sv
module conv_arbiter_bench;
  localparam int CH_W = 3, RC = 4, SC = 3, LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] en = '0, pr = '0, inj = '0;
  logic od = 1'b0, done = 1'b0;
  logic [1:0] pend = '0;
  logic [CH_W-1:0] ch0 = '0, ch1 = '0;

  logic start, src, cancel, busy, sample;
  logic [CH_W-1:0] chan, cur_chan;
  logic [1:0] ack;

  conv_arbiter #(.CH_W(CH_W), .ROUND_CYC(RC), .SAMPLE_CYC(SC)) u_conv_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .slot_en_i(en), .prio_i(pr), .inject_i(inj),
    .arb_on_demand_i(od), .q_pend_i(pend[0]), .q_chan_i(ch0), .s_pend_i(pend[1]),
    .s_chan_i(ch1), .conv_done_i(done), .start_o(start), .chan_o(chan), .src_o(src),
    .cancel_o(cancel), .ack_o(ack), .busy_o(busy), .cur_chan_o(cur_chan), .sample_o(sample));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_cnt = 0, m_samp = 0, be_left = 0, req_pct = 0;
  bit m_busy = 0, m_own = 0, be_act = 0;
  logic [CH_W-1:0] m_chan = '0;
  bit [1:0] prev_ack = '0, req_on = '0;
  // phase observations
  int n_start, n_start_s0, n_busy_start, n_cancel, last_start, n_bad_gap;
  int ack_cyc [2];

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic clear_obs();
    n_start = 0; n_start_s0 = 0; n_busy_start = 0; n_cancel = 0;
    last_start = -1; n_bad_gap = 0; ack_cyc[0] = -1; ack_cyc[1] = -1;
  endtask

  function automatic logic [CH_W-1:0] chan_of(input bit s);
    return s ? ch1 : ch0;
  endfunction

  task automatic step();
    bit beff, rend, hold, e_start, e_src, e_cancel;
    bit [1:0] elig, e_ack;
    logic [CH_W-1:0] e_chan;
    // source model: drop on ack, raise new requests at random
    for (int s = 0; s < 2; s++) begin
      if (prev_ack[s]) pend[s] = 1'b0;
      else if (!pend[s] && req_on[s] && $urandom_range(99) < req_pct) begin
        pend[s] = 1'b1;
        if (s == 0) ch0 = CH_W'($urandom_range(7));
        else        ch1 = CH_W'($urandom_range(7));
      end
    end
    done = be_act && be_left == 0;
    #1;
    beff = m_busy & ~done;
    for (int s = 0; s < 2; s++)
      elig[s] = en[s] & pend[s] & !(m_busy && m_own == s[0]) &
                (!beff | (inj[s] & pr[s] & !pr[m_own]));
    e_src    = elig[1] & (!elig[0] | (pr[1] & !pr[0]));
    rend     = (m_cnt == RC - 1);
    hold     = od & !(|(en & pend));
    e_start  = rend & (|elig);
    e_cancel = e_start & beff;
    e_chan   = chan_of(e_src);
    e_ack    = (done && m_busy) ? (m_own ? 2'b10 : 2'b01) : 2'b00;

    chk(start === e_start, "R3 start", int'(start), int'(e_start));
    if (e_start) begin
      chk(src === e_src, "R2 src", int'(src), int'(e_src));
      chk(chan === e_chan, "R3 chan", int'(chan), int'(e_chan));
    end
    chk(cancel === e_cancel, "R6 cancel", int'(cancel), int'(e_cancel));
    chk(ack === e_ack, "R7 ack", int'(ack), int'(e_ack));
    chk(busy === m_busy, "R8 busy", int'(busy), int'(m_busy));
    if (m_busy) chk(cur_chan === m_chan, "R8 cur_chan", int'(cur_chan), int'(m_chan));
    chk(sample === (m_samp != 0), "R9 sample", int'(sample), int'(m_samp != 0));

    if (start === 1'b1) begin
      n_start++;
      if (src === 1'b0) n_start_s0++;
      if (busy && !done) n_busy_start++;
      if (last_start >= 0 && ((cyc - last_start) % RC) != 0) n_bad_gap++;
      last_start = cyc;
    end
    if (cancel === 1'b1) n_cancel++;
    for (int s = 0; s < 2; s++) if (ack[s] === 1'b1 && ack_cyc[s] < 0) ack_cyc[s] = cyc;

    // model state after the coming edge
    m_cnt = hold ? 0 : (rend ? 0 : m_cnt + 1);
    if (e_start) begin
      m_busy = 1; m_own = e_src; m_chan = e_chan; m_samp = SC;
    end else if (done && m_busy) begin
      m_busy = 0; m_samp = 0;
    end else if (m_samp != 0) m_samp--;
    if (e_start) begin be_act = 1; be_left = LAT - 1; end
    else if (done) be_act = 0;
    else if (be_act) be_left--;
    prev_ack = e_ack;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    req_on = 2'b00;
    for (int i = 0; i < 200 && (pend != 2'b00 || m_busy); i++) begin
      if (!en[0] && pend[0]) en[0] = 1'b1;
      if (!en[1] && pend[1]) en[1] = 1'b1;
      step();
    end
  endtask

  initial begin
    int lat;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    // R10
    chk({start, cancel, ack, busy, sample} === 6'b0, "R10 reset outputs",
        int'({start, cancel, ack, busy, sample}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: only the scan slot enabled
    en = 2'b10; pr = 2'b00; inj = 2'b11; od = 1'b0; req_on = 2'b11; req_pct = 40;
    clear_obs(); run(300);
    chk(n_start_s0 == 0, "R1 disabled slot granted", n_start_s0, 0);
    chk(n_start > 0, "R1 enabled slot served", n_start, 1);

    // R2: scan high priority, then tie, both sources saturated
    en = 2'b11; pr = 2'b10; inj = 2'b00; req_pct = 100;
    clear_obs(); run(200);
    chk(n_start > n_start_s0, "R2 high priority scan wins", n_start - n_start_s0, 1);
    pr = 2'b00; run(200);

    // R5: wait-for-start mode never starts over a running conversion
    pr = 2'b01; inj = 2'b00; req_pct = 30;
    clear_obs(); run(300);
    chk(n_busy_start == 0, "R5 start while busy", n_busy_start, 0);
    // R4 permanent rounds: starts spaced by multiples of RC
    chk(n_bad_gap == 0, "R4 permanent spacing", n_bad_gap, 0);

    // R6: low-priority scan conversion aborted by high-priority queue
    drain();
    en = 2'b11; pr = 2'b01; inj = 2'b01; od = 1'b0;
    clear_obs();
    pend[1] = 1'b1; ch1 = 3'd5;
    for (int i = 0; i < 20 && !busy; i++) step();
    step();
    pend[0] = 1'b1; ch0 = 3'd2;
    run(40);
    chk(n_cancel == 1, "R6 one abort", n_cancel, 1);
    chk(ack_cyc[0] >= 0 && ack_cyc[1] > ack_cyc[0], "R6 aborted source retried after injection",
        ack_cyc[1], ack_cyc[0] + 1);
    chk(n_start == 3, "R6 starts scan, queue, scan", n_start, 3);

    // R4 on-demand: request from idle started RC-1 cycles later
    drain();
    od = 1'b1; pr = 2'b00; inj = 2'b00;
    run(9);
    pend[0] = 1'b1; ch0 = 3'd3;
    lat = 0;
    clear_obs();
    for (int i = 0; i < 20; i++) begin
      step();
      if (n_start > 0) break;
      lat++;
    end
    chk(lat == RC - 1, "R4 on-demand latency", lat, RC - 1);
    run(20);

    // mixed random: all settings vary, done and grant may coincide (R7)
    for (int k = 0; k < 30; k++) begin
      en = 2'($urandom_range(3)); pr = 2'($urandom_range(3));
      inj = 2'($urandom_range(3)); od = 1'($urandom_range(1));
      req_on = 2'b11; req_pct = 5 + int'($urandom_range(60));
      run(60);
    end
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got=%0d exp=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end
endmodule